// File: doc/BRIEF.md
# Stereo Sample Playback Buffer

This block sits on an 8-bit parallel bus and feeds a dual-channel DAC that takes parallel input. The bus master writes audio samples into a 9-bit wide FIFO. Each word holds the sample byte and a channel tag taken from address line 0. A free-running tick, derived from the system clock, takes one word per tick and hands it to the DAC. The DAC's channel select comes from the tag. Both channels share one interleaved stream, so the tick runs at twice the per-channel rate: 88.2 kHz for 44.1 kHz audio.

Each tick first loads the popped word onto the DAC data and channel outputs. A one-cycle write strobe follows half a tick period later, so the data is already settled when the DAC latches it. If the FIFO is empty at a tick, nothing is popped and no strobe is issued. The DAC then keeps converting its last value and never sees stale data.

A bus read returns a registered status byte that shows whether the FIFO is empty, half full or full. The active-high master reset empties the FIFO.

Top module: `audio_playout`

## Requirements
- R1: A word is pushed in each clock cycle where `bus_sel_n` and `bus_wr_n` are both sampled low. No push happens if either of them is high.
- R2: A pushed word takes `bus_din` as its sample and `bus_addr0` as its channel tag. On playback these appear on `dac_data` and on `dac_chan` (0 = channel A/right, 1 = channel B/left).
- R3: A write while the FIFO holds DEPTH words is dropped. The stored contents and their order stay unchanged.
- R4: `bus_drive` goes high in the cycle after `bus_sel_n` and `bus_rd_n` are both sampled low, and `bus_dout` then carries the status byte. In every other cycle `bus_drive` is low and `bus_dout` is 0.
- R5: Status byte: bit 0 = empty, bit 1 = 0, bit 2 = occupancy at least DEPTH/2, bit 3 = full, bits 7:4 = 0. It is refreshed every clock cycle from the FIFO flags.
- R6: Ticks occur every DIV = CLK_HZ/TICK_HZ clock cycles. Each tick pops at most one word, so two DAC strobes are always a whole multiple of DIV cycles apart.
- R7: `dac_strobe` is a single-cycle pulse. `dac_data` and `dac_chan` are loaded before the pulse and are held steady through it.
- R8: While the FIFO is empty, no `dac_strobe` is produced and `dac_data`/`dac_chan` keep their last values.
- R9: `rst` (synchronous, active high) empties the FIFO. After reset the status reads 8'h01, and `dac_strobe` and `bus_drive` are low.
- R10: Words are played back in push order. A push and a pop in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Master reset, synchronous, active high |
| bus_sel_n | input | 1 | Module select, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_addr0 | input | 1 | Address bit 0, stored as the channel tag |
| bus_din | input | SAMPLE_W | Write data from the bus |
| bus_dout | output | 8 | Status byte during a read, otherwise 0 |
| bus_drive | output | 1 | High while the block drives `bus_dout` |
| dac_data | output | SAMPLE_W | Sample presented to the DAC |
| dac_chan | output | 1 | DAC channel select |
| dac_strobe | output | 1 | DAC write pulse |

## Verification
The bench builds the block with CLK_HZ=64, TICK_HZ=1 and DEPTH=16, which gives a 64-cycle tick and a 16-word FIFO. With these values the bench can fill the FIFO to full within one tick window, write past full, and see the half-full flag at 8 words. It can then drain everything in about a thousand cycles.

Because the tick phase is known relative to each strobe, the bench can place a burst of writes across a tick. This exercises a push and a pop in the same cycle while the scoreboard checks order and channel tags.

// File: rtl/audio_playout_pkg.sv
package audio_playout_pkg;

  localparam int unsigned STATUS_W = 8;

  typedef struct packed {
    logic full;
    logic half;
    logic empty;
  } fifo_flags_t;

  // Status byte layout: [0]=empty, [1]=0, [2]=half, [3]=full, [7:4]=0
  function automatic logic [STATUS_W-1:0] pack_status(input fifo_flags_t f);
    logic [STATUS_W-1:0] s;
    s    = '0;
    s[0] = f.empty;
    s[2] = f.half;
    s[3] = f.full;
    return s;
  endfunction

endpackage

// File: rtl/playout_tick_gen.sv
module playout_tick_gen #(
  parameter int unsigned DIV = 1133
) (
  input  logic clk,
  input  logic rst,
  output logic tick,
  output logic mid
);

  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] HALF = CW'(DIV / 2 - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
      mid  <= 1'b0;
    end else begin
      cnt  <= (cnt == LAST) ? '0 : cnt + 1'b1;
      tick <= (cnt == LAST);
      mid  <= (cnt == HALF);
    end
  end

endmodule

// File: rtl/playout_fifo.sv
module playout_fifo
  import audio_playout_pkg::*;
#(
  parameter int unsigned WORD_W = 9,
  parameter int unsigned DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [WORD_W-1:0] push_word,
  input  logic              pop,
  output logic [WORD_W-1:0] pop_word,
  output fifo_flags_t       flags
);

  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0]   PTR_LAST = AW'(DEPTH - 1);
  localparam logic [CNTW-1:0] CNT_FULL = CNTW'(DEPTH);
  localparam logic [CNTW-1:0] CNT_HALF = CNTW'(DEPTH / 2);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CNTW-1:0]   count;
  logic              push_ok, pop_ok;

  assign flags.empty = (count == '0);
  assign flags.full  = (count == CNT_FULL);
  assign flags.half  = (count >= CNT_HALF);

  assign push_ok = push & ~flags.full;
  assign pop_ok  = pop & ~flags.empty;

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_word;
  end

  always_ff @(posedge clk) begin
    if (pop_ok) pop_word <= mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == PTR_LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == PTR_LAST) ? '0 : rd_ptr + 1'b1;
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/playout_sequencer.sv
module playout_sequencer #(
  parameter int unsigned SAMPLE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                mid,
  input  logic                fifo_empty,
  output logic                pop,
  input  logic [SAMPLE_W:0]   pop_word,
  output logic [SAMPLE_W-1:0] dac_data,
  output logic                dac_chan,
  output logic                dac_strobe
);

  logic load_q;
  logic armed;

  assign pop = tick & ~fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_q     <= 1'b0;
      armed      <= 1'b0;
      dac_data   <= '0;
      dac_chan   <= 1'b0;
      dac_strobe <= 1'b0;
    end else begin
      load_q     <= pop;
      dac_strobe <= mid & armed;
      if (load_q) begin
        dac_data <= pop_word[SAMPLE_W-1:0];
        dac_chan <= pop_word[SAMPLE_W];
        armed    <= 1'b1;
      end else if (mid) begin
        armed    <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/audio_playout.sv
module audio_playout
  import audio_playout_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned TICK_HZ  = 88_200,
  parameter int unsigned SAMPLE_W = 8,
  parameter int unsigned DEPTH    = 256
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel_n,
  input  logic                bus_wr_n,
  input  logic                bus_rd_n,
  input  logic                bus_addr0,
  input  logic [SAMPLE_W-1:0] bus_din,
  output logic [7:0]          bus_dout,
  output logic                bus_drive,
  output logic [SAMPLE_W-1:0] dac_data,
  output logic                dac_chan,
  output logic                dac_strobe
);

  localparam int unsigned DIV    = CLK_HZ / TICK_HZ;
  localparam int unsigned WORD_W = SAMPLE_W + 1;

  logic              wr_access, rd_access;
  logic              tick, mid, pop;
  logic [WORD_W-1:0] pop_word;
  fifo_flags_t       flags;
  logic [7:0]        status_q;

  assign wr_access = ~bus_sel_n & ~bus_wr_n;
  assign rd_access = ~bus_sel_n & ~bus_rd_n;

  playout_tick_gen #(.DIV(DIV)) u_tick (
    .clk  (clk),
    .rst  (rst),
    .tick (tick),
    .mid  (mid)
  );

  playout_fifo #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push      (wr_access),
    .push_word ({bus_addr0, bus_din}),
    .pop       (pop),
    .pop_word  (pop_word),
    .flags     (flags)
  );

  playout_sequencer #(.SAMPLE_W(SAMPLE_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .mid        (mid),
    .fifo_empty (flags.empty),
    .pop        (pop),
    .pop_word   (pop_word),
    .dac_data   (dac_data),
    .dac_chan   (dac_chan),
    .dac_strobe (dac_strobe)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q  <= 8'h01;
      bus_drive <= 1'b0;
      bus_dout  <= '0;
    end else begin
      status_q  <= pack_status(flags);
      bus_drive <= rd_access;
      bus_dout  <= rd_access ? status_q : '0;
    end
  end

endmodule

// File: rtl/audio_playout_chk.sv
module audio_playout_chk #(
  parameter int unsigned DIV      = 64,
  parameter int unsigned SAMPLE_W = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                bus_sel_n,
  input logic                bus_rd_n,
  input logic [7:0]          bus_dout,
  input logic                bus_drive,
  input logic [SAMPLE_W-1:0] dac_data,
  input logic                dac_chan,
  input logic                dac_strobe
);

  localparam int unsigned GW = $clog2(DIV + 1);

  logic [GW-1:0] gap;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (dac_strobe) begin
      gap  <= GW'(1);
      seen <= 1'b1;
    end else if (gap < GW'(DIV)) begin
      gap  <= gap + 1'b1;
    end
  end

  p_read_drive_r4: assert property (@(posedge clk) disable iff (rst)
    (!bus_sel_n && !bus_rd_n) |=> bus_drive);

  p_idle_release_r4: assert property (@(posedge clk) disable iff (rst)
    !(!bus_sel_n && !bus_rd_n) |=> (!bus_drive && bus_dout == 8'h00));

  p_status_reserved_r5: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> (bus_dout[7:4] == 4'h0 && !bus_dout[1]));

  p_status_consistent_r5: assert property (@(posedge clk) disable iff (rst)
    bus_drive |-> !(bus_dout[0] && (bus_dout[3] || bus_dout[2])));

  p_strobe_spacing_r6: assert property (@(posedge clk) disable iff (rst)
    (dac_strobe && seen) |-> gap == GW'(DIV));

  p_strobe_single_r7: assert property (@(posedge clk) disable iff (rst)
    dac_strobe |=> !dac_strobe);

  p_data_stable_r7: assert property (@(posedge clk) disable iff (rst)
    dac_strobe |-> ($stable(dac_data) && $stable(dac_chan)));

endmodule

bind audio_playout audio_playout_chk #(
  .DIV      (CLK_HZ / TICK_HZ),
  .SAMPLE_W (SAMPLE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_sel_n  (bus_sel_n),
  .bus_rd_n   (bus_rd_n),
  .bus_dout   (bus_dout),
  .bus_drive  (bus_drive),
  .dac_data   (dac_data),
  .dac_chan   (dac_chan),
  .dac_strobe (dac_strobe)
);

// File: tb/test_audio_playout.sv
`timescale 1ns/1ps
module test_audio_playout;

  localparam int unsigned CLK_HZ  = 64;
  localparam int unsigned TICK_HZ = 1;
  localparam int unsigned DIV     = CLK_HZ / TICK_HZ;
  localparam int unsigned DEPTH   = 16;
  localparam int unsigned LIMIT   = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1, bus_addr0 = 1'b0;
  logic [7:0] bus_din = '0;
  logic [7:0] bus_dout, dac_data;
  logic       bus_drive, dac_chan, dac_strobe;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int strobe_cnt = 0;
  int last_strobe = -1;
  bit done = 0;
  logic [8:0] exp_q[$];
  logic [7:0] prev_data;
  logic       prev_chan;

  always #5 clk = ~clk;

  audio_playout #(.CLK_HZ(CLK_HZ), .TICK_HZ(TICK_HZ), .SAMPLE_W(8), .DEPTH(DEPTH))
  i_audio_playout (
    .clk(clk), .rst(rst), .bus_sel_n(bus_sel_n), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .bus_addr0(bus_addr0), .bus_din(bus_din),
    .bus_dout(bus_dout), .bus_drive(bus_drive), .dac_data(dac_data),
    .dac_chan(dac_chan), .dac_strobe(dac_strobe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    cyc++;
    if (!rst && dac_strobe) begin
      strobe_cnt++;
      if (exp_q.size() == 0) begin
        check("R8 strobe with nothing queued", 16'(strobe_cnt), 16'(0));
      end else begin
        logic [8:0] e;
        e = exp_q.pop_front();
        check("R2/R10 played sample", {8'h0, dac_data}, {8'h0, e[7:0]});
        check("R2 channel tag", {15'h0, dac_chan}, {15'h0, e[8]});
      end
      check("R7 data held into strobe", {7'h0, prev_chan, prev_data}, {7'h0, dac_chan, dac_data});
      if (last_strobe >= 0)
        check("R6 strobe spacing multiple of DIV", 16'((cyc - last_strobe) % DIV), 16'(0));
      last_strobe = cyc;
    end
    prev_data = dac_data;
    prev_chan = dac_chan;
  end

  // watchdog
  always @(negedge clk) begin
    if (!done && cyc > LIMIT) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, LIMIT);
      summary();
    end
  end

  task automatic bus_write(input logic [7:0] d, input logic a0, input bit accepted);
    @(negedge clk);
    bus_sel_n = 1'b0; bus_wr_n = 1'b0; bus_rd_n = 1'b1;
    bus_din = d; bus_addr0 = a0;
    if (accepted) exp_q.push_back({a0, d});
  endtask

  task automatic bus_idle();
    @(negedge clk);
    bus_sel_n = 1'b1; bus_wr_n = 1'b1; bus_rd_n = 1'b1;
  endtask

  task automatic bus_read(output logic [7:0] v);
    bus_idle();
    @(negedge clk);
    @(negedge clk);
    bus_sel_n = 1'b0; bus_rd_n = 1'b0;
    @(negedge clk);
    v = bus_dout;
    check("R4 drive during read", {15'h0, bus_drive}, 16'h1);
    bus_sel_n = 1'b1; bus_rd_n = 1'b1;
  endtask

  task automatic wait_strobes(input int target);
    while (strobe_cnt < target) @(negedge clk);
  endtask

  initial begin
    logic [7:0] st;
    logic [7:0] hold_data;
    int         base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check("R9 strobe low after reset", {15'h0, dac_strobe}, 16'h0);
    check("R9 bus released after reset", {15'h0, bus_drive}, 16'h0);
    bus_read(st);
    check("R9 status empty after reset", {8'h0, st}, 16'h0001);

    // R1: partial selects push nothing
    @(negedge clk); bus_sel_n = 1'b1; bus_wr_n = 1'b0; bus_din = 8'hEE;
    @(negedge clk); bus_sel_n = 1'b0; bus_wr_n = 1'b1;
    bus_read(st);
    check("R1 no push without both strobes", {8'h0, st}, 16'h0001);

    // R4: read strobe without select
    @(negedge clk); bus_sel_n = 1'b1; bus_rd_n = 1'b0;
    @(negedge clk);
    check("R4 no drive without select", {15'h0, bus_drive}, 16'h0);
    check("R4 dout zero when idle", {8'h0, bus_dout}, 16'h0);
    bus_idle();

    // R3/R5: fill to full, then two dropped writes, before the first tick
    for (int i = 0; i < DEPTH; i++) bus_write(8'h10 + 8'(i), i[0], 1'b1);
    bus_write(8'hA5, 1'b1, 1'b0);
    bus_write(8'h5A, 1'b0, 1'b0);
    bus_read(st);
    check("R3/R5 status full and half", {8'h0, st}, 16'h000C);

    // drain; scoreboard proves dropped words never appear (R3)
    wait_strobes(DEPTH);
    check("R3 queue drained exactly", 16'(exp_q.size()), 16'h0);
    // next tick is DIV/2-1 cycles after this strobe
    bus_read(st);
    check("R8 status empty after drain", {8'h0, st}, 16'h0001);
    for (int i = 0; i < DEPTH / 2; i++) bus_write(8'h80 + 8'(i), ~i[0], 1'b1);
    bus_read(st);
    check("R5 half full at DEPTH/2", {8'h0, st}, 16'h0004);

    // R10: burst straddling a tick (push and pop in the same cycle)
    repeat (8) @(negedge clk);
    for (int i = 0; i < 7; i++) bus_write(8'hC0 + 8'(i), i[1], 1'b1);
    bus_idle();
    wait_strobes(DEPTH + DEPTH / 2 + 7);
    check("R10 all burst words played", 16'(exp_q.size()), 16'h0);

    // R8: empty FIFO holds the DAC
    base      = strobe_cnt;
    hold_data = dac_data;
    repeat (5 * DIV) @(negedge clk);
    check("R8 no strobe while empty", 16'(strobe_cnt), 16'(base));
    check("R8 dac data held", {8'h0, dac_data}, {8'h0, hold_data});

    // R9: reset clears a partly filled FIFO
    for (int i = 0; i < 3; i++) bus_write(8'h33, 1'b0, 1'b0);
    bus_idle();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    bus_read(st);
    check("R9 reset empties FIFO", {8'h0, st}, 16'h0001);
    base = strobe_cnt;
    repeat (2 * DIV) @(negedge clk);
    check("R9 no playback after reset", 16'(strobe_cnt), 16'(base));

    done = 1;
    summary();
  end

endmodule